// File: doc/BRIEF.md
# APB Dual-Timer Register Front End

This block is an APB slave that places two identical down-counting timer channels behind one 4 KB register window. Each channel has a reload value, a live count, a control byte, a raw event flag, a masked event flag, a write-only flag clear and a "background" reload path that changes the reload value without touching the running count. The counter in each channel can run as a 32-bit or 16-bit counter. It can be free-running or periodic, single-shot or repeating, and it counts every clock or every 16th or 256th clock.

The window also holds a write-only test-override pair and a read-only table of twelve identification bytes. Each channel drives its own interrupt line, and a third line is the OR of both. When the override is enabled, the two channel lines follow a software-written bit pair instead of the masked flags. System software uses the block as an ordinary memory-mapped timer. Transfers complete with zero wait states, reads are combinational from the address, and writes take effect at the clock edge that ends the access phase.

Top module: `twin_timer_apb`

## Requirements
- R1: After reset each channel reads CONTROL = 0x20, VALUE = 0xFFFFFFFF, LOAD = 0 and raw flag 0, and all interrupt outputs are low.
- R2: Channel k (k = 0, 1) occupies byte offsets k*0x20 + {0x00 reload, 0x04 count, 0x08 control, 0x0C flag clear, 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 background reload, which reads back the reload value}. Control bits are: bit 0 single-shot, bit 1 32-bit width, bits 3:2 divider select, bit 5 interrupt enable, bit 6 periodic, bit 7 run. Bit 4 and bits 31:8 read as zero.
- R3: A write to offset 0x00 sets the reload value and the count. In 16-bit width only the count's low half is replaced. A write to 0x18 sets only the reload value.
- R4: On each divider tick while running, a nonzero count (16-bit or 32-bit view) decrements by one, and reaching zero sets the raw flag. A tick at zero reloads the count: from the reload value in periodic mode, or with all ones of the active width in free-running mode.
- R5: In single-shot mode a count at zero stays at zero and does not set the flag again.
- R6: In 16-bit width only count bits 15:0 change and wrap at 16 bits. Bits 31:16 keep their stored value.
- R7: Divider select 00 ticks every running cycle, 01 ticks every 16th cycle and 10 or 11 every 256th cycle. The phase counter is cleared while the channel is stopped.
- R8: A write to offset 0x0C clears the raw flag. A zero-reaching tick in the same cycle wins.
- R9: The masked flag is the raw flag AND the interrupt enable, and each channel interrupt equals its masked flag when the override is off.
- R10: Offset 0xF00 bit 0 enables the override, and offset 0xF04 bits 1:0 then drive the channel 1 and channel 0 interrupts. Both registers are write-only and read zero.
- R11: The combined interrupt is high exactly when either channel interrupt is high.
- R12: Word offsets 0xFD0 through 0xFFC read one byte each, zero-extended, in this address order: 04,00,00,00,23,B8,1B,00,0D,F0,05,B1.
- R13: Reads of any other offset return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| chan_irq | output | 2 | Per-channel interrupt, bit 0 is channel 0 |
| any_irq | output | 1 | OR of the channel interrupts |

## Verification
The bench builds the block with the default divider exponents of 4 and 8, so the /16 and /256 taps both fire within a few hundred cycles and a 600-cycle run sees two slow ticks. With these values the phase counter is only eight bits wide, and the reference model can follow it every cycle. This also brings the tap alignment after a stop and restart into reach.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

   localparam int DATA_W = 32;
   localparam int HALF_W = 16;
   localparam int NUM_CH = 2;
   localparam int ADDR_W = 12;

   // Control byte, bit 7 down to bit 0
   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic       rsvd;
      logic [1:0] div_sel;
      logic       wide;
      logic       single;
   } ctrl_t;

   localparam logic [7:0] CTRL_MASK = 8'hEF;
   localparam logic [7:0] CTRL_RST  = 8'h20;

   typedef enum logic [4:0] {
      OFS_RELOAD = 5'h00,
      OFS_COUNT  = 5'h04,
      OFS_CTRL   = 5'h08,
      OFS_CLEAR  = 5'h0C,
      OFS_RAW    = 5'h10,
      OFS_MASKED = 5'h14,
      OFS_BGND   = 5'h18
   } reg_ofs_e;

   localparam logic [ADDR_W-1:0] TEST_EN_ADDR  = 12'hF00;
   localparam logic [ADDR_W-1:0] TEST_OUT_ADDR = 12'hF04;
   localparam logic [ADDR_W-1:0] ID_BASE_ADDR  = 12'hFD0;

   // Replace only the low half when the counter is in 16-bit width
   function automatic logic [DATA_W-1:0] merge_width(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic wide);
      return wide ? new_v : {old_v[DATA_W-1:HALF_W], new_v[HALF_W-1:0]};
   endfunction

endpackage

// File: rtl/twin_timer_presc.sv
module twin_timer_presc #(
   parameter int PRE_A_LOG2 = 4,
   parameter int PRE_B_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_sel,
   output logic       tick
);
   logic [PRE_B_LOG2-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase_q <= '0;
      else if (!run) phase_q <= '0;
      else           phase_q <= phase_q + 1'b1;
   end

   logic tap_a, tap_b;
   assign tap_a = &phase_q[PRE_A_LOG2-1:0];
   assign tap_b = &phase_q;

   always_comb begin
      unique case (div_sel)
         2'b00:   tick = run;
         2'b01:   tick = run & tap_a;
         default: tick = run & tap_b;
      endcase
   end
endmodule

// File: rtl/twin_timer_chan.sv
module twin_timer_chan
   import twin_timer_pkg::*;
#(
   parameter int PRE_A_LOG2 = 4,
   parameter int PRE_B_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_reload,
   input  logic              wr_bgnd,
   input  logic              wr_ctrl,
   input  logic              wr_clear,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reload_o,
   output logic [DATA_W-1:0] count_o,
   output ctrl_t             ctrl_o,
   output logic              flag_o
);
   logic [DATA_W-1:0] reload_q, count_q, count_n;
   ctrl_t             ctrl_q;
   logic              flag_q, tick;

   twin_timer_presc #(.PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .div_sel (ctrl_q.div_sel),
      .tick    (tick)
   );

   logic [DATA_W-1:0] view, dec, wrap_v;
   logic              at_zero, hit;

   assign view    = ctrl_q.wide ? count_q : {{HALF_W{1'b0}}, count_q[HALF_W-1:0]};
   assign at_zero = (view == '0);
   assign dec     = view - 1'b1;
   assign hit     = tick & ~at_zero & (dec == '0);

   always_comb begin
      if (ctrl_q.periodic)  wrap_v = reload_q;
      else                  wrap_v = '1;
   end

   always_comb begin
      count_n = count_q;
      if (wr_reload)
         count_n = merge_width(count_q, wdata, ctrl_q.wide);
      else if (tick) begin
         if (!at_zero)             count_n = merge_width(count_q, dec, ctrl_q.wide);
         else if (!ctrl_q.single)  count_n = merge_width(count_q, wrap_v, ctrl_q.wide);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         count_q  <= '1;
         ctrl_q   <= ctrl_t'(CTRL_RST);
         flag_q   <= 1'b0;
      end else begin
         count_q <= count_n;
         if (wr_reload || wr_bgnd) reload_q <= wdata;
         if (wr_ctrl)              ctrl_q   <= ctrl_t'(wdata[7:0] & CTRL_MASK);
         if (hit)                  flag_q   <= 1'b1;
         else if (wr_clear)        flag_q   <= 1'b0;
      end
   end

   assign reload_o = reload_q;
   assign count_o  = count_q;
   assign ctrl_o   = ctrl_q;
   assign flag_o   = flag_q;
endmodule

// File: rtl/twin_timer_idrom.sv
module twin_timer_idrom
   import twin_timer_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [7:0]        id_byte
);
   logic [ADDR_W-1:0] rel;
   logic [3:0]        idx;

   assign rel = addr - ID_BASE_ADDR;
   assign idx = rel[5:2];
   assign hit = (addr >= ID_BASE_ADDR) && (addr[1:0] == 2'b00);

   always_comb begin
      unique case (idx)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = 8'h23;
         4'd5:    id_byte = 8'hB8;
         4'd6:    id_byte = 8'h1B;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hF0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   end
endmodule

// File: rtl/twin_timer_apb.sv
module twin_timer_apb
   import twin_timer_pkg::*;
#(
   parameter int PRE_A_LOG2 = 4,
   parameter int PRE_B_LOG2 = 8
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic [NUM_CH-1:0] chan_irq,
   output logic              any_irq
);
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int SEL_LO = 5 + CH_W;

   generate
      if (PRE_A_LOG2 < 1 || PRE_B_LOG2 <= PRE_A_LOG2)
         $error("twin_timer_apb: divider exponents must satisfy 1 <= A < B");
      if (NUM_CH != 2)
         $error("twin_timer_apb: window layout expects two channels");
   endgenerate

   logic            wr_en, in_ch;
   logic [CH_W-1:0] ch_idx;
   logic [4:0]      reg_ofs;

   assign wr_en   = psel & penable & pwrite;
   assign in_ch   = (paddr[ADDR_W-1:SEL_LO] == '0);
   assign ch_idx  = paddr[5 +: CH_W];
   assign reg_ofs = paddr[4:0];

   logic [DATA_W-1:0] reload_a [NUM_CH];
   logic [DATA_W-1:0] count_a  [NUM_CH];
   ctrl_t             ctrl_a   [NUM_CH];
   logic [NUM_CH-1:0] flag_q, masked;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_ch;
      assign hit_ch = wr_en & in_ch & (ch_idx == CH_W'(i));
      twin_timer_chan #(.PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) u_chan (
         .clk       (pclk),
         .rst_n     (presetn),
         .wr_reload (hit_ch && reg_ofs == OFS_RELOAD),
         .wr_bgnd   (hit_ch && reg_ofs == OFS_BGND),
         .wr_ctrl   (hit_ch && reg_ofs == OFS_CTRL),
         .wr_clear  (hit_ch && reg_ofs == OFS_CLEAR),
         .wdata     (pwdata),
         .reload_o  (reload_a[i]),
         .count_o   (count_a[i]),
         .ctrl_o    (ctrl_a[i]),
         .flag_o    (flag_q[i])
      );
      assign masked[i] = flag_q[i] & ctrl_a[i].irq_en;
   end

   logic              itcr_q;
   logic [NUM_CH-1:0] itop_q;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         itcr_q <= 1'b0;
         itop_q <= '0;
      end else if (wr_en) begin
         if (paddr == TEST_EN_ADDR)  itcr_q <= pwdata[0];
         if (paddr == TEST_OUT_ADDR) itop_q <= pwdata[NUM_CH-1:0];
      end
   end

   assign chan_irq = itcr_q ? itop_q : masked;
   assign any_irq  = |chan_irq;

   logic       id_hit;
   logic [7:0] id_byte;

   twin_timer_idrom u_idrom (
      .addr    (paddr),
      .hit     (id_hit),
      .id_byte (id_byte)
   );

   always_comb begin
      prdata = '0;
      if (in_ch) begin
         unique case (reg_ofs)
            OFS_RELOAD, OFS_BGND: prdata = reload_a[ch_idx];
            OFS_COUNT:            prdata = count_a[ch_idx];
            OFS_CTRL:             prdata = {{(DATA_W-8){1'b0}}, ctrl_a[ch_idx]};
            OFS_RAW:              prdata = {{(DATA_W-1){1'b0}}, flag_q[ch_idx]};
            OFS_MASKED:           prdata = {{(DATA_W-1){1'b0}}, masked[ch_idx]};
            default:              prdata = '0;
         endcase
      end else if (id_hit) begin
         prdata = {{(DATA_W-8){1'b0}}, id_byte};
      end
   end
endmodule

// File: rtl/twin_timer_apb_chk.sv
module twin_timer_apb_chk
   import twin_timer_pkg::*;
(
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic [DATA_W-1:0] prdata,
   input logic [NUM_CH-1:0] chan_irq,
   input logic              itcr_q
);
   logic rd_cyc, wr_cyc;
   assign rd_cyc = psel & ~pwrite;
   assign wr_cyc = psel & penable & pwrite;

   // R10: override output pair lands on the interrupt pins one cycle later
   assert_test_drive_R10: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_cyc && paddr == TEST_OUT_ADDR && itcr_q) |=> (chan_irq == $past(pwdata[NUM_CH-1:0])));

   assert_test_wo_R10: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_cyc && (paddr == TEST_EN_ADDR || paddr == TEST_OUT_ADDR)) |-> (prdata == '0));

   assert_id_first_R12: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_cyc && paddr == 12'hFD0) |-> (prdata == 32'h0000_0004));

   assert_id_last_R12: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_cyc && paddr == 12'hFFC) |-> (prdata == 32'h0000_00B1));

   assert_flag_width_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_cyc && paddr[ADDR_W-1:6] == '0 && (paddr[4:0] == 5'h10 || paddr[4:0] == 5'h14))
      |-> (prdata[DATA_W-1:1] == '0));

   assert_undef_zero_R13: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_cyc && paddr >= 12'h040 && paddr < 12'hF00) |-> (prdata == '0));
endmodule

bind twin_timer_apb twin_timer_apb_chk u_chk (
   .pclk     (pclk),
   .presetn  (presetn),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .prdata   (prdata),
   .chan_irq (chan_irq),
   .itcr_q   (itcr_q)
);

// File: tb/twin_timer_apb_bench.sv
`timescale 1ns/1ps
module twin_timer_apb_bench;
   localparam int PA = 4;
   localparam int PB = 8;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [1:0]  chan_irq;
   logic        any_irq;

   always #2.5 pclk = ~pclk;

   twin_timer_apb #(.PRE_A_LOG2(PA), .PRE_B_LOG2(PB)) u_twin_timer_apb (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .chan_irq(chan_irq), .any_irq(any_irq)
   );

   int checks = 0, errors = 0;
   bit run_cmp = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_load [2];
   logic [31:0] m_val  [2];
   logic [7:0]  m_ctrl [2];
   int          m_ph   [2];
   bit          m_flag [2];
   bit          m_itcr;
   logic [1:0]  m_itop;
   int id_tab [12] = '{'h04, 'h00, 'h00, 'h00, 'h23, 'hB8, 'h1B, 'h00, 'h0D, 'hF0, 'h05, 'hB1};

   function automatic logic [31:0] fit(input logic [31:0] oldv, input logic [31:0] nv, input bit wide);
      return wide ? nv : {oldv[31:16], nv[15:0]};
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_load[c] = 0; m_val[c] = 32'hFFFF_FFFF; m_ctrl[c] = 8'h20; m_ph[c] = 0; m_flag[c] = 0;
      end
      m_itcr = 0; m_itop = 0;
   endtask

   task automatic model_step();
      bit wr;
      wr = psel && penable && pwrite;
      for (int c = 0; c < 2; c++) begin
         bit en, wide, tick, setf, clr;
         int ps;
         logic [31:0] cur, nv, nl;
         logic [7:0]  nc;
         en = m_ctrl[c][7]; wide = m_ctrl[c][1]; ps = int'(m_ctrl[c][3:2]);
         tick = en && (ps == 0 || (ps == 1 && (m_ph[c] % (1 << PA)) == (1 << PA) - 1)
                       || (ps >= 2 && (m_ph[c] % (1 << PB)) == (1 << PB) - 1));
         cur = wide ? m_val[c] : (m_val[c] & 32'h0000_FFFF);
         nv = m_val[c]; nl = m_load[c]; nc = m_ctrl[c]; setf = 0; clr = 0;
         if (tick) begin
            if (cur == 0) begin
               if (!m_ctrl[c][0]) nv = fit(m_val[c], m_ctrl[c][6] ? m_load[c] : 32'hFFFF_FFFF, wide);
            end else begin
               nv = fit(m_val[c], cur - 1, wide);
               setf = (cur == 1);
            end
         end
         if (wr && paddr < 12'h040 && int'(paddr[5]) == c) begin
            case (paddr[4:0])
               5'h00: begin nl = pwdata; nv = fit(m_val[c], pwdata, wide); end
               5'h18: nl = pwdata;
               5'h08: nc = pwdata[7:0] & 8'hEF;
               5'h0C: clr = 1;
               default: ;
            endcase
         end
         m_ph[c] = en ? (m_ph[c] + 1) % (1 << PB) : 0;
         m_val[c] = nv; m_load[c] = nl; m_ctrl[c] = nc;
         if (setf) m_flag[c] = 1; else if (clr) m_flag[c] = 0;
      end
      if (wr && paddr == 12'hF00) m_itcr = pwdata[0];
      if (wr && paddr == 12'hF04) m_itop = pwdata[1:0];
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int c;
      if (a < 12'h040) begin
         c = int'(a[5]);
         case (a[4:0])
            5'h00, 5'h18: return m_load[c];
            5'h04:        return m_val[c];
            5'h08:        return {24'h0, m_ctrl[c]};
            5'h10:        return {31'h0, m_flag[c]};
            5'h14:        return {31'h0, m_flag[c] & m_ctrl[c][5]};
            default:      return 0;
         endcase
      end
      if (a >= 12'hFD0 && a[1:0] == 2'b00) return id_tab[(a - 12'hFD0) >> 2];
      return 0;
   endfunction

   function automatic logic [1:0] model_irq();
      logic [1:0] r;
      for (int c = 0; c < 2; c++) r[c] = m_itcr ? m_itop[c] : (m_flag[c] & m_ctrl[c][5]);
      return r;
   endfunction

   initial model_reset();

   always @(posedge pclk) begin
      if (!presetn) model_reset();
      else model_step();
   end

   // every-cycle comparison of the interrupt pins
   always @(negedge pclk) begin
      if (run_cmp) begin
         chk("R9 R10 channel irq", {30'h0, chan_irq}, {30'h0, model_irq()});
         chk("R11 combined irq", {31'h0, any_irq}, {31'h0, |model_irq()});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge pclk); penable = 1;
      @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] e);
      @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge pclk); penable = 1; #1; d = prdata; e = model_read(a);
      @(negedge pclk); psel = 0; penable = 0;
   endtask

   task automatic rd_model(input logic [11:0] a, input string tag);
      logic [31:0] d, e;
      apb_rd(a, d, e);
      chk(tag, d, e);
   endtask

   task automatic rd_fixed(input logic [11:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] d, e;
      apb_rd(a, d, e);
      chk(tag, d, exp);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge pclk);
   endtask

   bit done = 0;

   initial begin
      repeat (4) @(negedge pclk);
      presetn = 1;
      run_cmp = 1;

      // R1 reset state
      rd_fixed(12'h008, 32'h20, "R1 ctrl ch0");
      rd_fixed(12'h028, 32'h20, "R1 ctrl ch1");
      rd_fixed(12'h004, 32'hFFFF_FFFF, "R1 count ch0");
      rd_fixed(12'h020, 32'h0, "R1 reload ch1");
      rd_fixed(12'h010, 32'h0, "R1 raw flag ch0");
      chk("R1 irq low", {30'h0, chan_irq}, 32'h0);

      // R12 identification bytes
      for (int k = 0; k < 12; k++) rd_fixed(12'hFD0 + 12'(4 * k), id_tab[k], "R12 id byte");

      // R2 control mask
      apb_wr(12'h028, 32'hFFFF_FFFF);
      rd_fixed(12'h028, 32'hEF, "R2 ctrl readback mask");
      apb_wr(12'h028, 32'h20);

      // R3 reload and background reload
      apb_wr(12'h008, 32'h62);
      apb_wr(12'h000, 32'd5);
      rd_fixed(12'h004, 32'd5, "R3 count follows reload");
      apb_wr(12'h018, 32'd9);
      rd_fixed(12'h000, 32'd9, "R3 bg reload value");
      rd_fixed(12'h004, 32'd5, "R3 bg leaves count");

      // R4 periodic 32-bit run
      apb_wr(12'h008, 32'hE2);
      wait_cyc(20);
      rd_model(12'h004, "R4 periodic count");
      rd_model(12'h010, "R4 raw flag");
      rd_fixed(12'h010, 32'h1, "R4 flag set after zero");

      // R5 single-shot on ch1
      apb_wr(12'h028, 32'h23);
      apb_wr(12'h020, 32'd3);
      apb_wr(12'h028, 32'hA3);
      wait_cyc(10);
      rd_fixed(12'h024, 32'd0, "R5 single-shot holds zero");
      rd_fixed(12'h030, 32'd1, "R5 single-shot flag");
      rd_fixed(12'h034, 32'd1, "R9 masked flag ch1");

      // R8 flag clear
      apb_wr(12'h02C, 32'h0);
      rd_fixed(12'h030, 32'd0, "R8 clear raw flag");
      wait_cyc(5);
      rd_fixed(12'h030, 32'd0, "R5 no refire at zero");

      // R9 masked flag with enable off
      apb_wr(12'h008, 32'h42);
      rd_fixed(12'h010, 32'd1, "R9 raw still set");
      rd_fixed(12'h014, 32'd0, "R9 masked off");
      apb_wr(12'h00C, 32'h0);

      // R6 16-bit free-running wrap
      apb_wr(12'h008, 32'h20);
      apb_wr(12'h000, 32'h1234_0002);
      rd_model(12'h004, "R6 16-bit reload merge");
      apb_wr(12'h008, 32'hA0);
      wait_cyc(6);
      rd_model(12'h004, "R6 16-bit wrap");
      rd_model(12'h010, "R6 flag at 16-bit zero");

      // R7 dividers
      apb_wr(12'h008, 32'h24);
      apb_wr(12'h000, 32'd1000);
      apb_wr(12'h008, 32'hA6);
      wait_cyc(50);
      rd_model(12'h004, "R7 divide by 16");
      apb_wr(12'h008, 32'hAA);
      wait_cyc(600);
      rd_model(12'h004, "R7 divide by 256");
      apb_wr(12'h008, 32'hAE);
      wait_cyc(300);
      rd_model(12'h004, "R7 select 11 as 256");

      // R10 R11 override
      apb_wr(12'hF04, 32'h2);
      apb_wr(12'hF00, 32'h1);
      wait_cyc(1);
      chk("R10 override pins", {30'h0, chan_irq}, 32'h2);
      chk("R11 combined high", {31'h0, any_irq}, 32'h1);
      rd_fixed(12'hF00, 32'h0, "R10 enable write-only");
      rd_fixed(12'hF04, 32'h0, "R10 output write-only");
      apb_wr(12'hF04, 32'h0);
      wait_cyc(1);
      chk("R11 combined low", {31'h0, any_irq}, 32'h0);
      apb_wr(12'hF00, 32'h0);

      // R13 undefined offsets
      rd_fixed(12'h01C, 32'h0, "R13 hole in channel");
      rd_fixed(12'h040, 32'h0, "R13 third channel slot");
      rd_fixed(12'h800, 32'h0, "R13 middle of window");
      rd_fixed(12'hF08, 32'h0, "R13 past test regs");
      rd_fixed(12'hFD2, 32'h0, "R13 unaligned id");
      apb_wr(12'h008, 32'h20);
      apb_wr(12'h01C, 32'hFFFF_FFFF);
      apb_wr(12'h040, 32'h1111);
      apb_wr(12'h800, 32'hFF);
      rd_model(12'h000, "R13 reload untouched");
      rd_model(12'h008, "R13 ctrl untouched");
      rd_fixed(12'h008, 32'h20, "R13 ctrl fixed");

      wait_cyc(4);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge pclk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule